// File: doc/BRIEF.md
# Configuration Load Sequence Controller

This block steps a programmable device through its configuration flow, one step at a time, once power is good. The steps come in a fixed order. A setup phase clears the configuration memory for a set number of cycles and then captures the 3-bit mode input once. The controller then waits for a sync indication and compares one identification word against a constant. It counts a set number of configuration data words, takes the verdict of an external CRC checker, and runs a timed startup phase before it raises done.

The captured mode code selects master or slave clocking. In master modes the block enables an internally generated configuration clock while the flow runs. In slave modes the clock comes from outside and the enable stays low. Once done is reached the enable drops, unless a keep-clock option is set at elaboration (persist or upset scanning).

A test-port request has priority over every other input. It parks the controller in a test state with the clock enable and done low. When the request is released the flow restarts from memory clear. A wrong identification word or a failed CRC verdict ends in an error state. A fresh rising edge on power-good restarts the flow from memory clear at any time.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: After reset the state output is 0 (idle), and clk_en, err and done are low.
- R2: A rising edge on pwr_good moves the block to state 1 (clear). It stays there for exactly CLR_CYCLES cycles, then spends one cycle in state 2 (mode sample), then enters state 3 (sync wait).
- R3: mode_pins is captured only on the cycle the block leaves state 2. Any later change on the pins has no effect on clk_en until the next restart.
- R4: Mode codes whose bit in MASTER_MASK is set are master modes (default: codes 0 to 3 master, 4 to 7 slave). In master mode, clk_en is high in states 3 to 7. In slave mode, clk_en stays low.
- R5: In state 3 the block waits for sync_found and then enters state 4 (ID check). data_valid pulses outside state 5 are ignored and do not count toward the load.
- R6: In state 4, the first id_valid compares id_word with DEV_ID. On a match the block enters state 5 (load). On a mismatch it enters state 9 (error) with err high and done low.
- R7: State 5 ends on the NUM_WORDS-th data_valid pulse received in it, and the block then enters state 6 (CRC verdict).
- R8: State 6 lasts one cycle. If crc_ok is high the block enters state 7 (startup); if it is low the block enters state 9 with err high.
- R9: State 7 lasts STARTUP_CYCLES cycles. The block then enters state 8 (done) with done high, err low, and clk_en low unless KEEP_CLK is set.
- R10: While test_act is high the block enters and stays in state 10 (test) with clk_en and done low. This takes priority over a power-good edge. After release the block enters state 1.
- R11: A pwr_good rising edge outside test restarts the flow at state 1, including from the done and error states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | Power-good level; its rising edge starts the flow |
| mode_pins | input | 3 | Mode selection code |
| sync_found | input | 1 | Sync pattern detected |
| id_word | input | IDW | Device identification word |
| id_valid | input | 1 | id_word valid strobe |
| data_valid | input | 1 | One configuration word accepted |
| crc_ok | input | 1 | CRC verdict, sampled in state 6 |
| test_act | input | 1 | Test port active; overrides all modes |
| state | output | 4 | Current step code |
| clk_en | output | 1 | Enable for the internally driven configuration clock |
| err | output | 1 | Error state reached |
| done | output | 1 | Configuration complete |

## Verification
The test-port override can coincide with a power-good rising edge, and the two must not mix: the override has to win. The bench provokes this from the done state by lowering power-good for one cycle and then raising it on the same edge that test_act rises. It judges the result by requiring state 10 with done and clk_en low on the next cycle, and then state 1 as soon as test_act is released. Inside the flow, stray data_valid pulses arrive during sync wait while the mode pins are flipped to the opposite clocking class. The word count and clk_en must both stay untouched by these, and the bench checks both.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
   typedef enum logic [3:0] {
      ST_IDLE   = 4'd0,
      ST_CLEAR  = 4'd1,
      ST_SAMPLE = 4'd2,
      ST_SYNC   = 4'd3,
      ST_IDCHK  = 4'd4,
      ST_LOAD   = 4'd5,
      ST_CRC    = 4'd6,
      ST_START  = 4'd7,
      ST_DONE   = 4'd8,
      ST_ERROR  = 4'd9,
      ST_TEST   = 4'd10
   } cfg_state_e;
endpackage

// File: rtl/cfg_step_cnt.sv
module cfg_step_cnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (clr) count <= '0;
      else if (inc) count <= count + 1'b1;
   end
endmodule

// File: rtl/cfg_mode_latch.sv
module cfg_mode_latch #(
   parameter int          MW          = 3,
   parameter logic [(1<<MW)-1:0] MASTER_MASK = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          capture,
   input  logic [MW-1:0] mode_pins,
   output logic [MW-1:0] mode_q,
   output logic          is_master
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= '0;
      else if (capture) mode_q <= mode_pins;
   end

   assign is_master = MASTER_MASK[mode_q];
endmodule

// File: rtl/cfg_clk_gate.sv
module cfg_clk_gate #(
   parameter bit KEEP_CLK = 1'b0
) (
   input  logic flow_act,
   input  logic in_done,
   input  logic is_master,
   output logic clk_en
);
   generate
      if (KEEP_CLK) begin : g_keep
         assign clk_en = is_master & (flow_act | in_done);
      end else begin : g_stop
         logic unused_done;
         assign unused_done = in_done;
         assign clk_en = is_master & flow_act;
      end
   endgenerate
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
   import cfg_seq_pkg::*;
#(
   parameter int          IDW            = 32,
   parameter logic [IDW-1:0] DEV_ID      = 32'h1A2B_3C4D,
   parameter int          CLR_CYCLES     = 8,
   parameter int          NUM_WORDS      = 16,
   parameter int          STARTUP_CYCLES = 4,
   parameter logic [7:0]  MASTER_MASK    = 8'h0F,
   parameter bit          PERSIST        = 1'b0,
   parameter bit          UPSET_SCAN     = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           pwr_good,
   input  logic [2:0]     mode_pins,
   input  logic           sync_found,
   input  logic [IDW-1:0] id_word,
   input  logic           id_valid,
   input  logic           data_valid,
   input  logic           crc_ok,
   input  logic           test_act,
   output logic [3:0]     state,
   output logic           clk_en,
   output logic           err,
   output logic           done
);
   localparam bit KEEP_CLK = PERSIST | UPSET_SCAN;
   localparam int MAX_A    = (CLR_CYCLES > NUM_WORDS) ? CLR_CYCLES : NUM_WORDS;
   localparam int CNT_MAX  = (MAX_A > STARTUP_CYCLES) ? MAX_A : STARTUP_CYCLES;
   localparam int CW       = $clog2(CNT_MAX + 1);
   localparam logic [CW-1:0] CLR_LAST  = CW'(CLR_CYCLES - 1);
   localparam logic [CW-1:0] LOAD_LAST = CW'(NUM_WORDS - 1);
   localparam logic [CW-1:0] SU_LAST   = CW'(STARTUP_CYCLES - 1);

   initial begin
      if (CLR_CYCLES < 1 || NUM_WORDS < 1 || STARTUP_CYCLES < 1)
         $fatal(1, "cfg_seq_ctrl: step lengths must be at least one");
      if (IDW < 1)
         $fatal(1, "cfg_seq_ctrl: IDW must be positive");
   end

   cfg_state_e     cur, nxt;
   logic           pg_q, pwr_rise;
   logic [CW-1:0]  cnt;
   logic           cnt_clr, cnt_inc;
   logic [2:0]     mode_q;
   logic           is_master;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pg_q <= 1'b0;
      else        pg_q <= pwr_good;
   end
   assign pwr_rise = pwr_good & ~pg_q;

   always_comb begin
      nxt = cur;
      unique case (cur)
         ST_IDLE:   nxt = ST_IDLE;
         ST_CLEAR:  if (cnt == CLR_LAST) nxt = ST_SAMPLE;
         ST_SAMPLE: nxt = ST_SYNC;
         ST_SYNC:   if (sync_found) nxt = ST_IDCHK;
         ST_IDCHK:  if (id_valid) nxt = (id_word == DEV_ID) ? ST_LOAD : ST_ERROR;
         ST_LOAD:   if (data_valid && cnt == LOAD_LAST) nxt = ST_CRC;
         ST_CRC:    nxt = crc_ok ? ST_START : ST_ERROR;
         ST_START:  if (cnt == SU_LAST) nxt = ST_DONE;
         ST_DONE:   nxt = ST_DONE;
         ST_ERROR:  nxt = ST_ERROR;
         ST_TEST:   nxt = ST_CLEAR;
         default:   nxt = ST_IDLE;
      endcase
      if (pwr_rise) nxt = ST_CLEAR;
      if (test_act) nxt = ST_TEST;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur <= ST_IDLE;
      else        cur <= nxt;
   end

   assign cnt_clr = (nxt != cur) | pwr_rise;
   assign cnt_inc = (cur == ST_CLEAR) | (cur == ST_START) |
                    ((cur == ST_LOAD) & data_valid);

   cfg_step_cnt #(.W(CW)) i_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (cnt_inc),
      .count (cnt)
   );

   cfg_mode_latch #(.MW(3), .MASTER_MASK(MASTER_MASK)) i_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (cur == ST_SAMPLE),
      .mode_pins (mode_pins),
      .mode_q    (mode_q),
      .is_master (is_master)
   );

   cfg_clk_gate #(.KEEP_CLK(KEEP_CLK)) i_gate (
      .flow_act  (cur >= ST_SYNC && cur <= ST_START),
      .in_done   (cur == ST_DONE),
      .is_master (is_master),
      .clk_en    (clk_en)
   );

   assign state = cur;
   assign err   = (cur == ST_ERROR);
   assign done  = (cur == ST_DONE);
endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk
   import cfg_seq_pkg::*;
#(
   parameter int             IDW      = 32,
   parameter logic [IDW-1:0] DEV_ID   = '0,
   parameter bit             KEEP_CLK = 1'b0
) (
   input logic           clk,
   input logic           rst_n,
   input logic [3:0]     state,
   input logic           clk_en,
   input logic           err,
   input logic           done,
   input logic           test_act,
   input logic           pwr_rise,
   input logic           id_valid,
   input logic [IDW-1:0] id_word,
   input logic           crc_ok,
   input logic [2:0]     mode_q
);
   a_r10_test_wins: assert property (@(posedge clk) disable iff (!rst_n)
      test_act |=> (state == ST_TEST && !clk_en && !done));

   a_r6_bad_id: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDCHK && id_valid && id_word != DEV_ID && !test_act && !pwr_rise)
      |=> (state == ST_ERROR && err && !done));

   a_r8_bad_crc: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CRC && !crc_ok && !test_act && !pwr_rise) |=> (state == ST_ERROR));

   a_r3_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_SAMPLE) |=> $stable(mode_q));

   a_r9_clk_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DONE && !KEEP_CLK) |-> !clk_en);

   a_r5_idchk_from_sync: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state == ST_IDCHK) |-> ($past(state) == ST_SYNC));

   a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_rise && !test_act) |=> (state == ST_CLEAR));
endmodule

bind cfg_seq_ctrl cfg_seq_chk #(.IDW(IDW), .DEV_ID(DEV_ID), .KEEP_CLK(KEEP_CLK)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .state    (state),
   .clk_en   (clk_en),
   .err      (err),
   .done     (done),
   .test_act (test_act),
   .pwr_rise (pwr_rise),
   .id_valid (id_valid),
   .id_word  (id_word),
   .crc_ok   (crc_ok),
   .mode_q   (mode_q)
);

// File: tb/test_cfg_seq_ctrl.sv
module test_cfg_seq_ctrl;
   localparam int          CLR_N  = 8;
   localparam int          WORDS  = 16;
   localparam int          SU_N   = 4;
   localparam logic [31:0] GOOD_ID = 32'h1A2B_3C4D;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_good = 1'b0;
   logic [2:0]  mode_pins = 3'd0;
   logic        sync_found = 1'b0;
   logic [31:0] id_word = '0;
   logic        id_valid = 1'b0;
   logic        data_valid = 1'b0;
   logic        crc_ok = 1'b0;
   logic        test_act = 1'b0;
   logic [3:0]  state;
   logic        clk_en, err, done;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   cfg_seq_ctrl i_cfg_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .mode_pins(mode_pins),
      .sync_found(sync_found), .id_word(id_word), .id_valid(id_valid),
      .data_valid(data_valid), .crc_ok(crc_ok), .test_act(test_act),
      .state(state), .clk_en(clk_en), .err(err), .done(done)
   );

   function automatic bit exp_master(input logic [2:0] m);
      return (m < 3'd4);
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run_flow(input logic [2:0] m, input bit id_good, input bit crc_good);
      int n;
      bit mst;
      mst = exp_master(m);
      pwr_good = 1'b0;
      @(negedge clk);
      pwr_good = 1'b1;
      mode_pins = m;
      @(negedge clk);
      check("R11 restart to clear", state, 1);
      n = 0;
      while (state == 4'd1 && n < 100) begin
         n++;
         @(negedge clk);
      end
      check("R2 clear length", n, CLR_N);
      check("R2 sample step", state, 2);
      @(negedge clk);
      check("R2 sync entry", state, 3);
      mode_pins = m ^ 3'b100;
      n = int'($urandom_range(1, 3));
      for (int k = 0; k < n; k++) begin
         data_valid = 1'b1;
         @(negedge clk);
      end
      data_valid = 1'b0;
      check("R5 waits for sync", state, 3);
      check("R3 R4 clk_en uses captured mode", clk_en, mst);
      sync_found = 1'b1;
      @(negedge clk);
      sync_found = 1'b0;
      check("R5 id check entry", state, 4);
      id_word = id_good ? GOOD_ID : (GOOD_ID ^ (32'h1 << $urandom_range(0, 31)));
      id_valid = 1'b1;
      @(negedge clk);
      id_valid = 1'b0;
      if (!id_good) begin
         check("R6 bad id state", state, 9);
         check("R6 bad id err", err, 1);
         check("R6 bad id done", done, 0);
         return;
      end
      check("R6 good id to load", state, 5);
      for (int w = 0; w < WORDS; w++) begin
         n = int'($urandom_range(0, 2));
         for (int g = 0; g < n; g++) @(negedge clk);
         data_valid = 1'b1;
         @(negedge clk);
         data_valid = 1'b0;
         if (w == WORDS - 2) check("R7 load not yet over", state, 5);
      end
      check("R7 load ends at word count", state, 6);
      crc_ok = crc_good;
      @(negedge clk);
      crc_ok = 1'b0;
      if (!crc_good) begin
         check("R8 bad crc state", state, 9);
         check("R8 bad crc err", err, 1);
         return;
      end
      check("R8 good crc to startup", state, 7);
      check("R4 clk_en in startup", clk_en, mst);
      n = 0;
      while (state == 4'd7 && n < 100) begin
         n++;
         @(negedge clk);
      end
      check("R9 startup length", n, SU_N);
      check("R9 done state", state, 8);
      check("R9 done high", done, 1);
      check("R9 err low", err, 0);
      check("R9 clock stopped", clk_en, 0);
   endtask

   initial begin
      void'($urandom(32'd20240));
      repeat (3) @(negedge clk);
      check("R1 reset state", state, 0);
      check("R1 reset clk_en", clk_en, 0);
      check("R1 reset err", err, 0);
      check("R1 reset done", done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle without power edge", state, 0);

      run_flow(3'd1, 1'b1, 1'b1);
      run_flow(3'd6, 1'b1, 1'b1);
      run_flow(3'd2, 1'b0, 1'b1);
      run_flow(3'd5, 1'b1, 1'b0);
      for (int i = 0; i < 8; i++)
         run_flow(3'($urandom_range(0, 7)), ($urandom_range(0, 3) != 0),
                  ($urandom_range(0, 3) != 0));

      run_flow(3'd0, 1'b1, 1'b1);
      pwr_good = 1'b0;
      @(negedge clk);
      pwr_good = 1'b1;
      test_act = 1'b1;
      @(negedge clk);
      check("R10 test beats power edge", state, 10);
      check("R10 done low in test", done, 0);
      check("R10 clk off in test", clk_en, 0);
      for (int k = 0; k < 3; k++) begin
         pwr_good = ~pwr_good;
         @(negedge clk);
      end
      check("R10 test holds", state, 10);
      pwr_good = 1'b1;
      test_act = 1'b0;
      @(negedge clk);
      check("R10 release to clear", state, 1);

      pwr_good = 1'b0;
      @(negedge clk);
      pwr_good = 1'b1;
      mode_pins = 3'd3;
      repeat (CLR_N + 2) @(negedge clk);
      check("R4 master clk_en in sync", clk_en, 1);
      test_act = 1'b1;
      @(negedge clk);
      test_act = 1'b0;
      check("R10 test during sync", state, 10);
      check("R10 clk off after override", clk_en, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule